// File: doc/BRIEF.md
# Event Aggregator With Multicast

This block gathers system events from two directions and turns them into host interrupt lines and outgoing global event messages. Discrete local inputs, each configured either to fire on every cycle it is high (pulse mode) or only on a 0-to-1 change (edge mode), are converted into a programmable global event ID and sent out on egress lane 0. Global events arriving on the ingress lane bump a saturating per-ID counter, and an ingress event that matches a multicast entry is fanned out into two new events, one on egress lane 0 and one on egress lane 1.

Every local conversion and every counted ingress event also sets a bit in a status register. Each host interrupt line has its own mask register and is raised while any status bit is both set and enabled in that mask. Software reaches all state through a 64-bit register port with a combinational read path and single-cycle writes. Each egress lane has a small FIFO with a valid/ready handshake; when a multicast event finds a lane FIFO full it is dropped and a sticky per-lane error bit records the loss.

Register word addresses: 0x00 status, 0x01+h mask of host h, 0x08 error, 0x10+i local input i configuration, 0x20+c counter c, 0x40+m multicast entry m.

Top module: `evt_aggr`

## Requirements
- R1: After reset, status, masks, error bits, configurations and counters read 0, both egress valids are low and all host interrupts are low.
- R2: Host line h is high exactly when (status & mask h) is non-zero; status bit i (i < N_LOCAL) belongs to local input i and bit N_LOCAL+c to counter c.
- R3: Writing the status word clears every bit written as 1; a bit being set in the same cycle stays set.
- R4: An ingress event whose ID c is below N_CNT increments counter c by one, saturating at all ones, and sets status bit N_LOCAL+c; IDs at or above N_CNT change no counter and no status bit.
- R5: Any write to a counter address clears that counter, and the clear wins over an increment in the same cycle.
- R6: A local input configured with bits [7:0] = output ID, bit 8 = enable and bit 9 = 0 (pulse mode) produces one event with that ID for every cycle it is sampled high.
- R7: With bit 9 = 1 (edge mode) a local input produces one event only when it is high and was low on the previous clock.
- R8: Local events detected together go onto lane 0 one per cycle, lowest input index first; a waiting event is held, not dropped, and a repeat from the same input while waiting merges into it.
- R9: A multicast entry (bits [7:0] match ID, [15:8] lane 0 ID, [23:16] lane 1 ID, bit 24 enable) that matches an ingress event emits its two IDs on lanes 0 and 1; the lowest matching entry wins, and on lane 0 it goes ahead of any local event in that cycle.
- R10: Each lane keeps its events in arrival order and holds valid and ID steady until ready is seen high.
- R11: A multicast event offered to a full lane FIFO is dropped and sets error bit 0 (lane 0) or bit 1 (lane 1); these bits stay set until written with 1.
- R12: A local input whose enable bit is 0 produces no event and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| loc_in | input | N_LOCAL | Local discrete event inputs |
| ing_valid | input | 1 | Ingress event present |
| ing_id | input | IDW | Ingress event ID |
| eg0_valid | output | 1 | Lane 0 event present |
| eg0_id | output | IDW | Lane 0 event ID |
| eg0_ready | input | 1 | Lane 0 consumer accepts |
| eg1_valid | output | 1 | Lane 1 event present |
| eg1_id | output | IDW | Lane 1 event ID |
| eg1_ready | input | 1 | Lane 1 consumer accepts |
| host_irq | output | N_HOST | Host interrupt lines |

## Verification
The bench builds the block with 4-bit counters and two-entry lane FIFOs, leaving the other parameters at their defaults. The narrow counters let twenty events drive a counter into saturation, and the shallow FIFOs let three back-to-back multicast hits overflow both lanes and set both sticky error bits within a handful of cycles. Random ingress traffic with random masks and random status clears is compared against a bench model of counters, status and interrupt lines.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_MASK = 8'h01;
  localparam logic [7:0] A_ERR  = 8'h08;
  localparam logic [7:0] A_LCFG = 8'h10;
  localparam logic [7:0] A_CNT  = 8'h20;
  localparam logic [7:0] A_MC   = 8'h40;

  // isolate the least significant set bit
  function automatic logic [63:0] lowest_one(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction

  // increment that stops at the all-ones value of a w-bit field
  function automatic logic [63:0] sat_inc(input logic [63:0] v, input int unsigned w);
    logic [63:0] top;
    top = (64'd1 << w) - 64'd1;
    return (v >= top) ? top : v + 64'd1;
  endfunction

  function automatic logic any_set(input logic [63:0] s, input logic [63:0] m);
    return |(s & m);
  endfunction
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/evt_local_conv.sv
module evt_local_conv #(
  parameter int N   = 4,
  parameter int IDW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          loc_in,
  input  logic [N-1:0]          en,
  input  logic [N-1:0]          edge_mode,
  input  logic [N-1:0][IDW-1:0] out_ids,
  input  logic                  can_grant,
  output logic [N-1:0]          det,
  output logic [N-1:0]          grant,
  output logic                  push,
  output logic [IDW-1:0]        push_id
);
  logic [N-1:0] prev_q, pend_q, cand;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_det
      assign det[gi] = en[gi] && (edge_mode[gi] ? (loc_in[gi] && !prev_q[gi]) : loc_in[gi]);
    end
  endgenerate

  assign cand  = pend_q | det;
  assign grant = can_grant ? N'(evt_pkg::lowest_one(64'(cand))) : '0;
  assign push  = |grant;

  always_comb begin
    push_id = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) push_id = out_ids[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= loc_in;
      pend_q <= cand & ~grant;
    end
  end
endmodule

// File: rtl/evt_ingress.sv
module evt_ingress #(
  parameter int N_CNT = 8,
  parameter int N_MC  = 2,
  parameter int IDW   = 8,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ing_valid,
  input  logic [IDW-1:0]            ing_id,
  input  logic [N_CNT-1:0]          cnt_clr,
  input  logic [N_MC-1:0]           mc_en,
  input  logic [N_MC-1:0][IDW-1:0]  mc_match,
  input  logic [N_MC-1:0][IDW-1:0]  mc_a,
  input  logic [N_MC-1:0][IDW-1:0]  mc_b,
  output logic [N_CNT-1:0][CNT_W-1:0] cnt,
  output logic [N_CNT-1:0]          cnt_hit,
  output logic                      mc_hit,
  output logic [IDW-1:0]            mc_a_id,
  output logic [IDW-1:0]            mc_b_id
);
  genvar gc;
  generate
    for (gc = 0; gc < N_CNT; gc++) begin : g_cnt
      assign cnt_hit[gc] = ing_valid && (ing_id == IDW'(gc));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt[gc] <= '0;
        else if (cnt_clr[gc]) cnt[gc] <= '0;
        else if (cnt_hit[gc]) cnt[gc] <= CNT_W'(evt_pkg::sat_inc(64'(cnt[gc]), CNT_W));
      end
    end
  endgenerate

  // scan from the top so the lowest matching entry is the one kept
  always_comb begin
    mc_hit  = 1'b0;
    mc_a_id = '0;
    mc_b_id = '0;
    for (int m = N_MC - 1; m >= 0; m--) begin
      if (ing_valid && mc_en[m] && (mc_match[m] == ing_id)) begin
        mc_hit  = 1'b1;
        mc_a_id = mc_a[m];
        mc_b_id = mc_b[m];
      end
    end
  end
endmodule

// File: rtl/evt_aggr.sv
module evt_aggr #(
  parameter int N_LOCAL    = 4,
  parameter int N_CNT      = 8,
  parameter int N_MC       = 2,
  parameter int N_HOST     = 2,
  parameter int IDW        = 8,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic [N_LOCAL-1:0] loc_in,
  input  logic               ing_valid,
  input  logic [IDW-1:0]     ing_id,
  output logic               eg0_valid,
  output logic [IDW-1:0]     eg0_id,
  input  logic               eg0_ready,
  output logic               eg1_valid,
  output logic [IDW-1:0]     eg1_id,
  input  logic               eg1_ready,
  output logic [N_HOST-1:0]  host_irq
);
  import evt_pkg::*;

  localparam int SW = N_LOCAL + N_CNT;

  // software-visible state
  logic [SW-1:0]                stat_q;
  logic [N_HOST-1:0][SW-1:0]    mask_q;
  logic [1:0]                   err_q;
  logic [N_LOCAL-1:0][IDW-1:0]  lid_q;
  logic [N_LOCAL-1:0]           len_q, ledge_q;
  logic [N_MC-1:0][IDW-1:0]     mmatch_q, ma_q, mb_q;
  logic [N_MC-1:0]              men_q;

  // named internal events
  logic [N_LOCAL-1:0]           loc_det, loc_grant;
  logic                         loc_push;
  logic [IDW-1:0]               loc_push_id;
  logic [N_CNT-1:0]             cnt_hit, cnt_clr;
  logic [N_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]             cnt0_w;
  logic                         mc_hit;
  logic [IDW-1:0]               mc_a_id, mc_b_id;
  logic                         f0_full, f0_empty, f1_full, f1_empty;
  logic                         f0_push;
  logic [IDW-1:0]               f0_din;
  logic                         ovf0, ovf1;
  logic                         wr_stat, wr_err;
  logic [SW-1:0]                stat_set, stat_clr;
  logic [1:0]                   err_clr;

  assign cnt0_w  = cnt_q[0];
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_err  = reg_wr && (reg_addr == A_ERR);

  genvar gc;
  generate
    for (gc = 0; gc < N_CNT; gc++) begin : g_clr
      assign cnt_clr[gc] = reg_wr && (reg_addr == 8'(A_CNT + 8'(gc)));
    end
  endgenerate

  evt_local_conv #(.N(N_LOCAL), .IDW(IDW)) u_loc (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_in    (loc_in),
    .en        (len_q),
    .edge_mode (ledge_q),
    .out_ids   (lid_q),
    .can_grant (!mc_hit && !f0_full),
    .det       (loc_det),
    .grant     (loc_grant),
    .push      (loc_push),
    .push_id   (loc_push_id)
  );

  evt_ingress #(.N_CNT(N_CNT), .N_MC(N_MC), .IDW(IDW), .CNT_W(CNT_W)) u_ing (
    .clk       (clk),
    .rst_n     (rst_n),
    .ing_valid (ing_valid),
    .ing_id    (ing_id),
    .cnt_clr   (cnt_clr),
    .mc_en     (men_q),
    .mc_match  (mmatch_q),
    .mc_a      (ma_q),
    .mc_b      (mb_q),
    .cnt       (cnt_q),
    .cnt_hit   (cnt_hit),
    .mc_hit    (mc_hit),
    .mc_a_id   (mc_a_id),
    .mc_b_id   (mc_b_id)
  );

  // lane 0: multicast first, otherwise one granted local event
  assign f0_push = mc_hit || loc_push;
  assign f0_din  = mc_hit ? mc_a_id : loc_push_id;
  assign ovf0    = mc_hit && f0_full;
  assign ovf1    = mc_hit && f1_full;

  evt_fifo #(.W(IDW), .DEPTH(FIFO_DEPTH)) u_f0 (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f0_push),
    .din   (f0_din),
    .pop   (eg0_ready),
    .full  (f0_full),
    .empty (f0_empty),
    .dout  (eg0_id)
  );

  evt_fifo #(.W(IDW), .DEPTH(FIFO_DEPTH)) u_f1 (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (mc_hit),
    .din   (mc_b_id),
    .pop   (eg1_ready),
    .full  (f1_full),
    .empty (f1_empty),
    .dout  (eg1_id)
  );

  assign eg0_valid = !f0_empty;
  assign eg1_valid = !f1_empty;

  // status and error: set beats write-one-to-clear
  assign stat_set = {cnt_hit, loc_det};
  assign stat_clr = wr_stat ? reg_wdata[SW-1:0] : '0;
  assign err_clr  = wr_err ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      err_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      err_q  <= (err_q & ~err_clr) | {ovf1, ovf0};
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      lid_q    <= '0;
      len_q    <= '0;
      ledge_q  <= '0;
      mmatch_q <= '0;
      ma_q     <= '0;
      mb_q     <= '0;
      men_q    <= '0;
    end else if (reg_wr) begin
      for (int h = 0; h < N_HOST; h++) begin
        if (reg_addr == 8'(A_MASK + 8'(h))) mask_q[h] <= reg_wdata[SW-1:0];
      end
      for (int i = 0; i < N_LOCAL; i++) begin
        if (reg_addr == 8'(A_LCFG + 8'(i))) begin
          lid_q[i]   <= reg_wdata[IDW-1:0];
          len_q[i]   <= reg_wdata[8];
          ledge_q[i] <= reg_wdata[9];
        end
      end
      for (int m = 0; m < N_MC; m++) begin
        if (reg_addr == 8'(A_MC + 8'(m))) begin
          mmatch_q[m] <= reg_wdata[IDW-1:0];
          ma_q[m]     <= reg_wdata[8 +: IDW];
          mb_q[m]     <= reg_wdata[16 +: IDW];
          men_q[m]    <= reg_wdata[24];
        end
      end
    end
  end

  // interrupt lines
  always_comb begin
    for (int h = 0; h < N_HOST; h++) begin
      host_irq[h] = any_set(64'(stat_q), 64'(mask_q[h]));
    end
  end

  // combinational readback
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT) reg_rdata = 64'(stat_q);
    if (reg_addr == A_ERR)  reg_rdata = 64'(err_q);
    for (int h = 0; h < N_HOST; h++) begin
      if (reg_addr == 8'(A_MASK + 8'(h))) reg_rdata = 64'(mask_q[h]);
    end
    for (int i = 0; i < N_LOCAL; i++) begin
      if (reg_addr == 8'(A_LCFG + 8'(i)))
        reg_rdata = 64'({ledge_q[i], len_q[i], 8'(lid_q[i])});
    end
    for (int c = 0; c < N_CNT; c++) begin
      if (reg_addr == 8'(A_CNT + 8'(c))) reg_rdata = 64'(cnt_q[c]);
    end
    for (int m = 0; m < N_MC; m++) begin
      if (reg_addr == 8'(A_MC + 8'(m)))
        reg_rdata = 64'({men_q[m], 8'(mb_q[m]), 8'(ma_q[m]), 8'(mmatch_q[m])});
    end
  end
endmodule

// File: rtl/evt_aggr_chk.sv
module evt_aggr_chk #(
  parameter int N_LOCAL = 4,
  parameter int N_HOST  = 2,
  parameter int IDW     = 8,
  parameter int SW      = 12,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [7:0]         reg_addr,
  input logic [63:0]        reg_wdata,
  input logic               eg0_valid,
  input logic [IDW-1:0]     eg0_id,
  input logic               eg0_ready,
  input logic               eg1_valid,
  input logic [IDW-1:0]     eg1_id,
  input logic               eg1_ready,
  input logic [N_HOST-1:0]  host_irq,
  input logic [SW-1:0]      stat_q,
  input logic [1:0]         err_q,
  input logic [N_LOCAL-1:0] loc_grant,
  input logic               mc_hit,
  input logic               f0_full,
  input logic               f1_full,
  input logic [CNT_W-1:0]   cnt0
);
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> (host_irq == '0)); // R2

  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == evt_pkg::A_CNT) |=> (cnt0 == '0)); // R5

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_grant)); // R8

  AST_MC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_hit && !f0_full && !f1_full) |=> (eg0_valid && eg1_valid)); // R9

  AST_EG0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eg0_valid && !eg0_ready) |=> (eg0_valid && $stable(eg0_id))); // R10

  AST_EG1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eg1_valid && !eg1_ready) |=> (eg1_valid && $stable(eg1_id))); // R10

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_hit && f1_full) |=> err_q[1]); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !(reg_wr && reg_addr == evt_pkg::A_ERR && reg_wdata[0])) |=> err_q[0]); // R11
endmodule

bind evt_aggr evt_aggr_chk #(
  .N_LOCAL (N_LOCAL),
  .N_HOST  (N_HOST),
  .IDW     (IDW),
  .SW      (N_LOCAL + N_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .eg0_valid (eg0_valid),
  .eg0_id    (eg0_id),
  .eg0_ready (eg0_ready),
  .eg1_valid (eg1_valid),
  .eg1_id    (eg1_id),
  .eg1_ready (eg1_ready),
  .host_irq  (host_irq),
  .stat_q    (stat_q),
  .err_q     (err_q),
  .loc_grant (loc_grant),
  .mc_hit    (mc_hit),
  .f0_full   (f0_full),
  .f1_full   (f1_full),
  .cnt0      (cnt0_w)
);

// File: tb/sim_evt_aggr.sv
module sim_evt_aggr;
  localparam int NL = 4, NC = 8, NH = 2, IDW = 8, CW = 4, FD = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [63:0]    reg_wdata = '0;
  logic [63:0]    reg_rdata;
  logic [NL-1:0]  loc_in = '0;
  logic           ing_valid = 1'b0;
  logic [IDW-1:0] ing_id = '0;
  logic           eg0_valid, eg1_valid;
  logic [IDW-1:0] eg0_id, eg1_id;
  logic           eg0_ready = 1'b0, eg1_ready = 1'b0;
  logic [NH-1:0]  host_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_aggr #(.N_LOCAL(NL), .N_CNT(NC), .N_HOST(NH), .IDW(IDW), .CNT_W(CW), .FIFO_DEPTH(FD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .loc_in(loc_in), .ing_valid(ing_valid), .ing_id(ing_id),
    .eg0_valid(eg0_valid), .eg0_id(eg0_id), .eg0_ready(eg0_ready),
    .eg1_valid(eg1_valid), .eg1_id(eg1_id), .eg1_ready(eg1_ready), .host_irq(host_irq)
  );

  function automatic logic [CW-1:0] m_sat(input logic [CW-1:0] v);
    return (v == {CW{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic [NH-1:0] m_irq(input logic [11:0] s, input logic [11:0] m0, input logic [11:0] m1);
    return {(s & m1) != 0, (s & m0) != 0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ing(input logic [IDW-1:0] id);
    @(negedge clk);
    ing_valid = 1'b1; ing_id = id;
    @(negedge clk);
    ing_valid = 1'b0;
  endtask

  task automatic pop0(input string req, input logic [IDW-1:0] exp);
    chk(req, eg0_valid, 1);
    chk(req, eg0_id, exp);
    eg0_ready = 1'b1;
    @(negedge clk);
    eg0_ready = 1'b0;
  endtask

  task automatic pop1(input string req, input logic [IDW-1:0] exp);
    chk(req, eg1_valid, 1);
    chk(req, eg1_id, exp);
    eg1_ready = 1'b1;
    @(negedge clk);
    eg1_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [CW-1:0] cm [NC];
    logic [11:0] sm, mk0, mk1;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 status", d, 0);
    rd(8'h01, d); chk("R1 mask0", d, 0);
    rd(8'h08, d); chk("R1 err", d, 0);
    rd(8'h10, d); chk("R1 lcfg0", d, 0);
    rd(8'h23, d); chk("R1 cnt3", d, 0);
    chk("R1 egress", {eg0_valid, eg1_valid}, 0);
    chk("R1 irq", host_irq, 0);

    // R4 counting, saturation, out of range
    repeat (5) ing(8'd3);
    rd(8'h23, d); chk("R4 cnt3", d, 5);
    repeat (20) ing(8'd1);
    rd(8'h21, d); chk("R4 saturate", d, 15);
    rd(8'h00, d); chk("R4 status", d, 12'h0A0);
    ing(8'd9);
    rd(8'h00, d); chk("R4 id out of range status", d, 12'h0A0);
    rd(8'h21, d); chk("R4 id out of range cnt", d, 15);

    // R5 clear, and clear beats increment
    wr(8'h21, 0);
    rd(8'h21, d); chk("R5 clear", d, 0);
    repeat (2) ing(8'd2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h22; reg_wdata = 0; ing_valid = 1'b1; ing_id = 8'd2;
    @(negedge clk);
    reg_wr = 1'b0; ing_valid = 1'b0;
    rd(8'h22, d); chk("R5 clear wins", d, 0);

    // R2 / R3 masks and write-one-to-clear
    wr(8'h00, 64'hFFF);
    rd(8'h00, d); chk("R3 clear all", d, 0);
    ing(8'd3);
    wr(8'h01, 64'h080);
    wr(8'h02, 64'h010);
    chk("R2 irq one line", host_irq, 2'b01);
    wr(8'h02, 64'h090);
    chk("R2 irq both", host_irq, 2'b11);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 64'h080; ing_valid = 1'b1; ing_id = 8'd3;
    @(negedge clk);
    reg_wr = 1'b0; ing_valid = 1'b0;
    rd(8'h00, d); chk("R3 set wins", d, 12'h080);
    wr(8'h00, 64'h080);
    rd(8'h00, d); chk("R3 w1c", d, 0);
    chk("R2 irq low", host_irq, 0);

    // R6 pulse mode, R10 hold under back-pressure
    wr(8'h10, 64'h121);
    @(negedge clk); loc_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    loc_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 held", {eg0_valid, eg0_id}, {1'b1, 8'h21});
    pop0("R6 pulse first", 8'h21);
    pop0("R6 pulse second", 8'h21);
    chk("R6 no extra", eg0_valid, 0);

    // R7 edge mode
    wr(8'h11, 64'h333);
    @(negedge clk); loc_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    loc_in[1] = 1'b0;
    @(negedge clk);
    pop0("R7 edge", 8'h33);
    chk("R7 single", eg0_valid, 0);

    // R8 simultaneous locals, lowest first
    wr(8'h12, 64'h145);
    @(negedge clk); loc_in = 4'b0101;
    @(negedge clk); loc_in = 4'b0000;
    repeat (2) @(negedge clk);
    pop0("R8 order first", 8'h21);
    pop0("R8 order second", 8'h45);
    chk("R8 drained", eg0_valid, 0);

    // R9 multicast, lowest entry wins, ahead of local
    wr(8'h40, 64'h1515005);
    wr(8'h41, 64'h1616105);
    @(negedge clk); loc_in[0] = 1'b1; ing_valid = 1'b1; ing_id = 8'd5;
    @(negedge clk); loc_in[0] = 1'b0; ing_valid = 1'b0;
    repeat (2) @(negedge clk);
    pop0("R9 lane0 multicast", 8'h50);
    pop0("R9 lane0 local after", 8'h21);
    pop1("R9 lane1 multicast", 8'h51);
    chk("R9 lanes empty", {eg0_valid, eg1_valid}, 0);

    // R11 overflow on both lanes
    @(negedge clk); ing_valid = 1'b1; ing_id = 8'd5;
    repeat (3) @(negedge clk);
    ing_valid = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h08, d); chk("R11 err sticky", d, 3);
    pop1("R11 lane1 kept", 8'h51);
    pop1("R11 lane1 kept", 8'h51);
    chk("R11 third dropped", eg1_valid, 0);
    pop0("R11 lane0 kept", 8'h50);
    pop0("R11 lane0 kept", 8'h50);
    wr(8'h08, 64'h3);
    rd(8'h08, d); chk("R11 err cleared", d, 0);

    // R12 disabled input
    wr(8'h00, 64'hFFF);
    wr(8'h13, 64'h077);
    @(negedge clk); loc_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    loc_in[3] = 1'b0;
    @(negedge clk);
    chk("R12 no event", eg0_valid, 0);
    rd(8'h00, d); chk("R12 no status", d, 0);

    // random ingress traffic against the model: R2 R3 R4
    wr(8'h40, 0); wr(8'h41, 0);
    for (int c = 0; c < NC; c++) begin
      wr(8'h20 + 8'(c), 0);
      cm[c] = '0;
    end
    wr(8'h00, 64'hFFF);
    sm = '0; mk0 = '0; mk1 = 12'h090;
    wr(8'h01, 0);
    for (int k = 0; k < 6; k++) begin
      repeat (40) begin
        @(negedge clk);
        ing_valid = 1'($urandom % 2);
        ing_id = 8'($urandom % 12);
        if (ing_valid && ing_id < NC) begin
          cm[ing_id] = m_sat(cm[ing_id]);
          sm[NL + int'(ing_id)] = 1'b1;
        end
      end
      @(negedge clk); ing_valid = 1'b0;
      for (int c = 0; c < NC; c++) begin
        rd(8'h20 + 8'(c), d); chk("R4 random count", d, 64'(cm[c]));
      end
      rd(8'h00, d); chk("R4 random status", d, 64'(sm));
      mk0 = 12'($urandom);
      wr(8'h01, 64'(mk0));
      chk("R2 random irq", host_irq, m_irq(sm, mk0, mk1));
      d = 64'(12'($urandom));
      wr(8'h00, d);
      sm = sm & ~d[11:0];
      rd(8'h00, d); chk("R3 random clear", d, 64'(sm));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule